// File: doc/BRIEF.md
# Two-Input Path Detector

The block watches a pair of single-bit inputs and raises a single output only when the pair has walked through the values 00, then 01, then 11, with each value reached by a change of exactly one input bit. The very next change of the inputs drops the output again. After that, the machine refuses to detect anything until it has seen the pair go back to 00. The block is the clocked form of a fundamental-mode machine. Every clock cycle it samples the pair, and it treats any difference from the value sampled in the previous cycle as one input event.

The inputs pass through a two-flop synchronizer before the state machine sees them. The machine has four states held in two bits:

| State | Code | Meaning |
|-------|------|---------|
| IDLE | 00 | Waiting at 00 |
| SAW01 | 01 | Saw 00 then 01 |
| DETECT | 11 | Path complete, output high |
| WAIT | 10 | Locked out until the pair is back at 00 |

These codes are arranged so that every state move flips exactly one state bit.

The moves are:

- IDLE→SAW01 when the pair goes to 01.
- IDLE→WAIT when the pair goes to 10 or 11, or on a double change.
- SAW01→DETECT when the pair goes to 11.
- SAW01→IDLE when the pair goes back to 00.
- DETECT→WAIT on any change.
- WAIT→IDLE once the pair reads 00.

One case needs care. A double change out of SAW01 would need a two-bit code jump (01→10). The machine therefore routes it as SAW01→IDLE, a one-cycle transit, and then IDLE→WAIT. The output stays low throughout the transit. The output is driven from a register that is loaded with "next state is DETECT".

Top module: `pair_path_detector`

## Requirements
- R1: While reset is high, and after it is released with the inputs at 00, Z is 0 and the state is IDLE (code 00).
- R2: When the inputs step 00→01→11, one bit at a time, Z becomes 1. It stays 1 for as long as the inputs hold 11.
- R3: When Z is 1, the next change of either input clears Z.
- R4: No other order of input values drives Z to 1. For example, 00→10→11 leaves Z at 0, and so does 01→11 without a prior 00.
- R5: After Z is cleared, Z stays 0 until the inputs have returned to 00. A path 00→01→11 after that return sets Z again.
- R6: If both input bits change between two samples, Z stays 0 and the machine goes to WAIT. From SAW01 it gets there through a one-cycle transit in IDLE.
- R7: The state codes are IDLE=00, SAW01=01, DETECT=11 and WAIT=10. Each state update changes at most one state bit.
- R8: Z never shows a one-cycle pulse while the machine passes through an intermediate state. In every cycle, Z is 1 exactly when the state is DETECT.
- R9: An input change reaches Z at the third rising clock edge after it is applied: two synchronizer flops, then the state and output registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x1_in | input | 1 | First input bit (upper bit of the pair) |
| x2_in | input | 1 | Second input bit (lower bit of the pair) |
| z_out | output | 1 | Registered detect output |

## Verification
A wrong state shows at z_out within three clock edges of the input change that should have moved the machine:

- A missed lockout in WAIT shows up as a spurious high after a path such as 01→11 with no prior 00.
- A missing move into DETECT shows up as a low where a high is expected.

The double-change cases, and the transit from SAW01 through IDLE, are sampled every cycle, so a one-cycle pulse on z_out is caught there. The latency check pins the output to the third edge, which exposes any added or missing pipeline stage.

// File: rtl/pair_path_pkg.sv
package pair_path_pkg;

    localparam int PAIR_W = 2;

    typedef logic [PAIR_W-1:0] pair_t;

    // Gray-adjacent codes: every legal move flips a single bit
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SAW01  = 2'b01,
        ST_DETECT = 2'b11,
        ST_WAIT   = 2'b10
    } path_state_t;

    localparam pair_t PAIR_ZERO = 2'b00;
    localparam pair_t PAIR_LOW  = 2'b01;
    localparam pair_t PAIR_BOTH = 2'b11;

endpackage

// File: rtl/pair_sync.sv
module pair_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                end
            end
            assign sync_out[b] = chain_q[LAST];
        end
    endgenerate
endmodule

// File: rtl/pair_change.sv
module pair_change #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    output logic             changed,
    output logic             multi
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= cur;
        end
    end

    assign diff    = cur ^ prev_q;
    assign changed = |diff;
    assign multi   = ($countones(diff) > 1);
endmodule

// File: rtl/path_fsm.sv
module path_fsm
    import pair_path_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pair_t       pair,
    input  logic        changed,
    input  logic        multi,
    output path_state_t state,
    output logic        detect
);
    path_state_t state_q;
    path_state_t state_d;
    logic        det_q;

    // next-state table
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (multi)                  state_d = ST_WAIT;
                else if (pair == PAIR_ZERO) state_d = ST_IDLE;
                else if (pair == PAIR_LOW)  state_d = ST_SAW01;
                else                        state_d = ST_WAIT;
            end
            ST_SAW01: begin
                // double change: transit via IDLE (01->00->10)
                if (multi)                  state_d = ST_IDLE;
                else if (pair == PAIR_ZERO) state_d = ST_IDLE;
                else if (pair == PAIR_BOTH) state_d = ST_DETECT;
                else                        state_d = ST_SAW01;
            end
            ST_DETECT: begin
                if (changed || pair != PAIR_BOTH) state_d = ST_WAIT;
                else                              state_d = ST_DETECT;
            end
            ST_WAIT: begin
                if (pair == PAIR_ZERO) state_d = ST_IDLE;
                else                   state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register, loaded from the next state
    always_ff @(posedge clk) begin
        if (rst) det_q <= 1'b0;
        else     det_q <= (state_d == ST_DETECT);
    end

    assign state  = state_q;
    assign detect = det_q;
endmodule

// File: rtl/pair_path_detector.sv
module pair_path_detector
    import pair_path_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic x1_in,
    input  logic x2_in,
    output logic z_out
);
    pair_t       raw_pair;
    pair_t       sync_pair;
    logic        pair_changed;
    logic        pair_multi;
    path_state_t cur_state;

    assign raw_pair = {x1_in, x2_in};

    pair_sync #(.WIDTH(PAIR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_pair),
        .sync_out (sync_pair)
    );

    pair_change #(.WIDTH(PAIR_W)) u_change (
        .clk     (clk),
        .rst     (rst),
        .cur     (sync_pair),
        .changed (pair_changed),
        .multi   (pair_multi)
    );

    path_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pair    (sync_pair),
        .changed (pair_changed),
        .multi   (pair_multi),
        .state   (cur_state),
        .detect  (z_out)
    );
endmodule

// File: rtl/pair_path_detector_chk.sv
module pair_path_detector_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] st,
    input logic [1:0] sp,
    input logic       chg,
    input logic       z
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (st == 2'b00 && !z));

    // R7
    one_bit_move_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(st ^ $past(st)) <= 1);

    // R8
    z_matches_detect_chk: assert property (@(posedge clk) disable iff (rst)
        z == (st == 2'b11));

    // R3
    change_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (z && chg) |=> !z);

    // R4
    rise_needs_path_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(z) |-> ($past(st) == 2'b01 && $past(sp) == 2'b11));

    // R5
    wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b10 && sp != 2'b00) |=> (st == 2'b10 && !z));
endmodule

bind pair_path_detector pair_path_detector_chk u_chk (
    .clk (clk),
    .rst (rst),
    .st  (cur_state),
    .sp  (sync_pair),
    .chg (pair_changed),
    .z   (z_out)
);

// File: tb/pair_path_detector_tb.sv
`timescale 1ns/1ps
module pair_path_detector_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x1 = 1'b0;
    logic x2 = 1'b0;
    logic z;

    int checks = 0;
    int fails  = 0;
    bit last_exp = 1'b0;
    bit exp_q[$];
    string tag_q[$];
    event sample_ev;

    always #2 clk = ~clk;

    pair_path_detector u_dut (
        .clk   (clk),
        .rst   (rst),
        .x1_in (x1),
        .x2_in (x2),
        .z_out (z)
    );

    // monitor: pops expected values and compares against the port
    always @(sample_ev) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (z !== e) begin
            fails++;
            $display("FAIL %s: z=%0b expected %0b", t, z, e);
        end
    end

    // driver: apply a pair, queue the settled Z, watch for pulses
    task automatic step(input logic [1:0] v, input bit e, input string t);
        bit quiet;
        bit pulse;
        quiet = (!last_exp && !e);
        pulse = 1'b0;
        @(negedge clk);
        {x1, x2} = v;
        exp_q.push_back(e);
        tag_q.push_back(t);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (quiet && z) pulse = 1'b1;
        end
        ->sample_ev;
        #0.1;
        if (quiet) begin
            checks++;
            if (pulse) begin
                fails++;
                $display("FAIL R8 %s: pulse z=1 expected 0", t);
            end
        end
        last_exp = e;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (z !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: z=%0b expected 0", z);
        end
        rst = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (z !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: z=%0b expected 0", z);
        end

        // R9 latency: third rising edge after the change
        step(2'b01, 1'b0, "R9 setup 01");
        @(negedge clk); {x1, x2} = 2'b11;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (z !== 1'b0) begin
            fails++;
            $display("FAIL R9 early: z=%0b expected 0", z);
        end
        @(negedge clk);
        checks++;
        if (z !== 1'b1) begin
            fails++;
            $display("FAIL R9 edge3: z=%0b expected 1", z);
        end
        last_exp = 1'b1;
        step(2'b11, 1'b1, "R2 hold 11");
        step(2'b01, 1'b0, "R3 clear via 01");
        step(2'b11, 1'b0, "R5 no 00 yet");
        step(2'b00, 1'b0, "R5 back to 00");
        step(2'b01, 1'b0, "R2 01");
        step(2'b11, 1'b1, "R5 redetect");
        step(2'b10, 1'b0, "R3 clear via 10");
        step(2'b00, 1'b0, "R5 00");
        step(2'b10, 1'b0, "R4 00->10");
        step(2'b11, 1'b0, "R4 10->11");
        step(2'b00, 1'b0, "R4 back 00");
        step(2'b01, 1'b0, "R4 01");
        step(2'b00, 1'b0, "R4 01->00");
        step(2'b01, 1'b0, "R2 01 again");
        step(2'b11, 1'b1, "R2 detect after retry");
        step(2'b00, 1'b0, "R6 double 11->00");
        step(2'b11, 1'b0, "R6 double 00->11");
        step(2'b01, 1'b0, "R6 wait holds");
        step(2'b00, 1'b0, "R6 00");
        step(2'b01, 1'b0, "R6 01");
        step(2'b10, 1'b0, "R6 double 01->10 transit");
        step(2'b11, 1'b0, "R6 wait after transit");
        step(2'b00, 1'b0, "R6 00 release");
        step(2'b01, 1'b0, "R2 01 final");
        step(2'b11, 1'b1, "R2 final detect");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule